// File: doc/BRIEF.md
# Accumulator-Based Fractional Clock Divider

This block derives a slower clock from its input clock. The average division ratio is N + F. N is an unsigned integer and F is an unsigned W-bit fraction, where 2^W stands for one whole unit. Each output period lasts either N or N+1 input cycles.

A phase accumulator chooses between the two lengths. At every period boundary it adds F to its W-bit value. When that addition carries out, the carry flag is raised for the whole of the following period, and that period is stretched by one input cycle. The output is high for the first half of each period and low for the rest, so its rising edge marks the start of a period. The accumulator value and the carry flag are also visible at the outputs, which lets the stored phase error be observed.

The divisor inputs are taken only in the first cycle of each period. Software or a loop controller can therefore change them at any time without disturbing a period that is already running.

Top module: `frac_clk_div`

## Requirements
- R1: While rst_ni is low, and in the first cycle after it is released, clk_o is 1, acc_o is 0 and carry_o is 0. Period 0 after reset has carry 0 and lasts exactly N input cycles.
- R2: Each output period lasts N + carry_o input cycles, where carry_o is the value held during that period.
- R3: During period k after reset, counting the first period as 0, acc_o equals (k·F) mod 2^W. The value of F used is the one sampled at the start of each earlier period.
- R4: carry_o during period k (k ≥ 1) is 1 exactly when the W-bit addition acc + F at the end of period k−1 carries out. carry_o and acc_o do not change within a period.
- R5: Within a period of length L, clk_o is 1 for the first floor(L/2) input cycles and 0 for the remaining cycles. Every 0→1 transition of clk_o starts a new period.
- R6: div_int_i and div_frac_i are sampled only in the first cycle of a period. A change at any later cycle of that period has no effect on its length, its high time or the accumulation made at its end.
- R7: A div_int_i value below 2 is handled as 2.
- R8: Over periods 1 to 2^W after reset, the total number of input cycles equals N·2^W + F.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Input clock being divided |
| rst_ni | input | 1 | Asynchronous reset, active low |
| div_int_i | input | N_W | Integer part N of the ratio |
| div_frac_i | input | FRAC_W | Fractional part F, where 2^FRAC_W stands for 1.0 |
| clk_o | output | 1 | Divided clock; its rising edge marks the start of a period |
| acc_o | output | FRAC_W | Phase accumulator value for the current period |
| carry_o | output | 1 | Set for a period stretched to N+1 cycles |

## Verification
The hardest condition to reach is an update of the divisor inputs in the middle of a period that must not take effect until the next boundary. The stimulus changes both N and F two cycles into a period. The expected period lengths then show that the old N is kept until the boundary, and the accumulation made at the end of that period still uses the old F. The 2^W-period average is the other hard case, because it needs a full wrap of the accumulator. The bench therefore runs with a narrow fraction width so that a complete cycle of carries fits in a short run. F values that carry on every period and values that carry only once are both covered.

// File: rtl/fcd_pkg.sv
package fcd_pkg;
  localparam int unsigned MIN_DIV = 2;
endpackage

// File: rtl/fcd_period_cnt.sv
module fcd_period_cnt #(
  parameter int unsigned N_W = 8
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [N_W-1:0] n_i,
  input  logic           carry_i,
  output logic           start_o,
  output logic           wrap_o,
  output logic           clk_o
);
  localparam int unsigned CW = N_W + 1;

  logic [CW-1:0] cnt_q, mod_q, n_eff, half;

  assign n_eff   = ({1'b0, n_i} < CW'(fcd_pkg::MIN_DIV)) ? CW'(fcd_pkg::MIN_DIV) : {1'b0, n_i};
  assign half    = mod_q >> 1;
  assign start_o = (cnt_q == '0);
  assign wrap_o  = !start_o && (cnt_q == mod_q - CW'(1));
  // first cycle is always high; mod_q is refreshed at the end of it
  assign clk_o   = start_o || (cnt_q < half);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      mod_q <= CW'(fcd_pkg::MIN_DIV);
    end else begin
      if (start_o) mod_q <= n_eff + CW'(carry_i);
      cnt_q <= wrap_o ? '0 : cnt_q + CW'(1);
    end
  end
endmodule

// File: rtl/fcd_phase_acc.sv
module fcd_phase_acc #(
  parameter int unsigned FRAC_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [FRAC_W-1:0] f_i,
  input  logic              start_i,
  input  logic              wrap_i,
  output logic [FRAC_W-1:0] acc_o,
  output logic              carry_o
);
  logic [FRAC_W-1:0] f_q, acc_q;
  logic              carry_q;
  logic [FRAC_W:0]   sum;

  assign sum     = {1'b0, acc_q} + {1'b0, f_q};
  assign acc_o   = acc_q;
  assign carry_o = carry_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      f_q     <= '0;
      acc_q   <= '0;
      carry_q <= 1'b0;
    end else begin
      if (start_i) f_q <= f_i;
      if (wrap_i) begin
        acc_q   <= sum[FRAC_W-1:0];
        carry_q <= sum[FRAC_W];
      end
    end
  end
endmodule

// File: rtl/frac_clk_div.sv
module frac_clk_div #(
  parameter int unsigned N_W    = 8,
  parameter int unsigned FRAC_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_W-1:0]    div_int_i,
  input  logic [FRAC_W-1:0] div_frac_i,
  output logic              clk_o,
  output logic [FRAC_W-1:0] acc_o,
  output logic              carry_o
);
  logic period_start, period_wrap;

  fcd_period_cnt #(.N_W(N_W)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .n_i     (div_int_i),
    .carry_i (carry_o),
    .start_o (period_start),
    .wrap_o  (period_wrap),
    .clk_o   (clk_o)
  );

  fcd_phase_acc #(.FRAC_W(FRAC_W)) u_acc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .f_i     (div_frac_i),
    .start_i (period_start),
    .wrap_i  (period_wrap),
    .acc_o   (acc_o),
    .carry_o (carry_o)
  );
endmodule

// File: rtl/frac_clk_div_chk.sv
module frac_clk_div_chk #(
  parameter int unsigned N_W    = 8,
  parameter int unsigned FRAC_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              wrap_i,
  input logic              clk_o,
  input logic [FRAC_W-1:0] acc_o,
  input logic              carry_o
);
  logic [N_W+1:0] len_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     len_q <= '0;
    else if (wrap_i) len_q <= '0;
    else             len_q <= len_q + 1'b1;
  end

  // R4
  carry_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wrap_i |=> $stable(carry_o));
  // R4
  acc_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wrap_i |=> $stable(acc_o));
  // R4
  carry_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_i |=> (carry_o == (acc_o < $past(acc_o))));
  // R5
  start_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> clk_o);
  // R5
  end_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_i |-> !clk_o);
  // R5
  rise_is_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(clk_o) |-> start_i);
  // R2
  len_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_i |-> (len_q >= 1 && len_q <= (1 << N_W)));
endmodule

bind frac_clk_div frac_clk_div_chk #(.N_W(N_W), .FRAC_W(FRAC_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .start_i (period_start),
  .wrap_i  (period_wrap),
  .clk_o   (clk_o),
  .acc_o   (acc_o),
  .carry_o (carry_o)
);

// File: tb/frac_clk_div_tb.sv
module frac_clk_div_tb;
  localparam int N_W    = 8;
  localparam int FRAC_W = 8;
  localparam int FULL   = 1 << FRAC_W;

  // n, f, expected cycles over periods 1..2^W
  localparam int NVEC = 6;
  localparam int VEC [NVEC][3] = '{
    '{3,   'h40, 832},
    '{2,   'hFF, 767},
    '{5,   'h00, 1280},
    '{255, 'h01, 65281},
    '{2,   'h80, 640},
    '{0,   'h10, 528}
  };

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic [N_W-1:0]    div_int_i = '0;
  logic [FRAC_W-1:0] div_frac_i = '0;
  logic              clk_o;
  logic [FRAC_W-1:0] acc_o;
  logic              carry_o;

  int n_tests = 0;
  int n_fail  = 0;

  frac_clk_div #(.N_W(N_W), .FRAC_W(FRAC_W)) u_dut (
    .clk_i, .rst_ni, .div_int_i, .div_frac_i, .clk_o, .acc_o, .carry_o
  );

  always #10 clk_i = ~clk_i;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset(input int n, input int f);
    @(negedge clk_i);
    rst_ni     = 1'b0;
    div_int_i  = N_W'(n);
    div_frac_i = FRAC_W'(f);
    repeat (2) @(negedge clk_i);
    check(clk_o === 1'b1, "R1 clk_o in reset", clk_o, 1);
    check(acc_o === '0, "R1 acc_o in reset", acc_o, 0);
    check(carry_o === 1'b0, "R1 carry_o in reset", carry_o, 0);
    rst_ni = 1'b1;
  endtask

  // called at the negedge of a period's first cycle; returns at the next one
  task automatic measure(output int len, output int hi, output int c, output int a, output bit stab);
    logic prev;
    len = 0; hi = 0; c = carry_o; a = acc_o; stab = 1'b1;
    forever begin
      if (clk_o) hi++;
      if (carry_o !== c[0] || acc_o !== a[FRAC_W-1:0]) stab = 1'b0;
      len++;
      prev = clk_o;
      @(negedge clk_i);
      if (clk_o && !prev) break;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk_i);
    n_fail++;
    $display("FAIL R8 watchdog: act=timeout exp=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int len, hi, c, a, m_acc, m_c, n_eff, total;
    bit stab, bad;

    for (int v = 0; v < NVEC; v++) begin
      do_reset(VEC[v][0], VEC[v][1]);
      check(clk_o === 1'b1 && acc_o === '0 && carry_o === 1'b0, "R1 first cycle", clk_o, 1);
      n_eff = (VEC[v][0] < 2) ? 2 : VEC[v][0];
      m_acc = 0; m_c = 0; total = 0; bad = 1'b0;
      for (int k = 0; k <= FULL; k++) begin
        if (k > 0) begin
          m_acc = m_acc + VEC[v][1];
          m_c   = (m_acc >= FULL) ? 1 : 0;
          m_acc = m_acc % FULL;
        end
        measure(len, hi, c, a, stab);
        if (k == 0) check(len == n_eff, "R1 period 0 length", len, n_eff);
        if (k > 0) total += len;
        if (len != n_eff + m_c) begin
          check(0, (VEC[v][0] < 2) ? "R7 clamped length" : "R2 period length", len, n_eff + m_c);
          bad = 1'b1;
        end
        if (hi != len / 2) begin check(0, "R5 high time", hi, len / 2); bad = 1'b1; end
        if (a != m_acc) begin check(0, "R3 accumulator", a, m_acc); bad = 1'b1; end
        if (c != m_c) begin check(0, "R4 carry", c, m_c); bad = 1'b1; end
        if (!stab) begin check(0, "R4 hold within period", 0, 1); bad = 1'b1; end
      end
      check(!bad, "R2 R3 R4 R5 per-period sweep", bad, 0);
      check(total == VEC[v][2], "R8 total cycles", total, VEC[v][2]);
    end

    // R6: inputs changed two cycles into period 0
    do_reset(4, 0);
    fork
      begin
        repeat (2) @(negedge clk_i);
        div_int_i  = N_W'(6);
        div_frac_i = FRAC_W'('h80);
      end
    join_none
    measure(len, hi, c, a, stab);
    check(len == 4, "R6 period 0 keeps old N", len, 4);
    check(hi == 2, "R6 period 0 high time", hi, 2);
    measure(len, hi, c, a, stab);
    check(len == 6 && a == 0, "R6 old F used at end of period 0", a, 0);
    measure(len, hi, c, a, stab);
    check(len == 6 && a == 'h80 && c == 0, "R6 new F accumulated", a, 'h80);
    measure(len, hi, c, a, stab);
    check(len == 7 && c == 1 && a == 0, "R6 carry stretches period", len, 7);

    // R7: N=1 handled as 2
    do_reset(1, 0);
    measure(len, hi, c, a, stab);
    check(len == 2 && hi == 1, "R7 N=1 clamped", len, 2);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule